// File: doc/BRIEF.md
# Complementary Three-Phase PWM Generator

This block drives three half-bridges. Each phase has a high-side and a low-side gate output. The two outputs of a phase are never on together, and a programmable gap of `Td` clocks separates them. The block does not delay each edge with its own timer. It runs two triangle counters in lockstep, and the second counter sits `Td` above the first. The high-side output turns on while the lower counter is above the phase duty. The low-side output turns on while the upper counter is below the duty. Because the counters are offset, every switch-over has a band in which both outputs are off.

Software loads a set of buffer registers through a single write port while the mode is off. The buffers are the half period, the upper counter's top limit (half period plus `Td`), the dead time, three duty values and the output polarity. When the mode enable goes high, all the buffers except the dead time are copied into the working compare registers in one clock. At the same time the lower counter starts from 0 and the upper counter starts from `Td`. The duty values can be changed only at that entry point.

Top module: `cpwm_deadband`

## Requirements
- R1: After reset the mode is off, the polarity bits are 0 and all six outputs are low.
- R2: While the mode is off, every high-side output equals the high-side polarity bit and every low-side output equals the low-side polarity bit (the inactive level).
- R3: Mode entry happens in the first clock that samples `mode_en` high after it was low. In that clock the half period, the top limit and the three duty buffers are copied together into the compare registers. Buffer writes made later have no effect on the outputs until the next entry.
- R4: The lower counter starts at 0 and the upper counter starts at `Td`. Both step by one each clock. The lower counter turns around at the half period and at 0. The upper counter turns around at the top limit and at `Td`. With top = half + `Td`, the upper counter always equals the lower counter plus `Td`.
- R5: In a running phase, the high-side output is active while the clamped duty is below the lower counter. The low-side output is active while the clamped duty is above the upper counter.
- R6: A duty value larger than the half period acts as the half period.
- R7: The two outputs of a phase are never active together. After one output goes inactive, at least `Td` clocks with both outputs inactive pass before the other output goes active.
- R8: Polarity register bit 0 applies to the three high-side outputs and bit 1 to the three low-side outputs. A 1 makes those outputs active-low.
- R9: Writes to the dead-time register or to the polarity register are ignored while the mode is on.
- R10: The write select codes are: 0 half period, 1 top limit, 2 dead time, 3/4/5 duty of phase 0/1/2, 6 polarity. A write lands on the rising clock edge that samples `wr_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (R10) |
| wr_data | input | CW | Write data |
| mode_en | input | 1 | Complementary mode enable (level) |
| pwm_pos | output | NPH | High-side gate outputs, one per phase |
| pwm_neg | output | NPH | Low-side gate outputs, one per phase |

## Verification
The outputs are decoded combinationally from registered state. A write or a mode entry sampled at one rising edge is therefore visible in the half cycle that follows, and each later counter step shows up one edge later. The reference model advances on the same rising edges as the design and derives both counters from the number of clocks since entry, using a triangle formula rather than a step machine. All comparisons, including the measurement of each phase's dead-band gap, are made on the falling edge, half a cycle after the edge the model predicts.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_HALF  = 3'd0,
    SEL_TOP   = 3'd1,
    SEL_DEAD  = 3'd2,
    SEL_DUTY0 = 3'd3,
    SEL_DUTY1 = 3'd4,
    SEL_DUTY2 = 3'd5,
    SEL_POL   = 3'd6
  } reg_sel_e;

  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NPH = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic [CW-1:0]           wr_data,
  input  logic                    locked,
  output logic [CW-1:0]           buf_half,
  output logic [CW-1:0]           buf_top,
  output logic [CW-1:0]           dead_q,
  output logic [NPH-1:0][CW-1:0]  buf_duty,
  output logic                    pol_pos,
  output logic                    pol_neg
);
  logic wr_half, wr_top, wr_dead, wr_pol;

  assign wr_half = wr_en && (wr_sel == SEL_HALF);
  assign wr_top  = wr_en && (wr_sel == SEL_TOP);
  assign wr_dead = wr_en && (wr_sel == SEL_DEAD) && !locked;
  assign wr_pol  = wr_en && (wr_sel == SEL_POL) && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_half <= '0;
      buf_top  <= '0;
      dead_q   <= '0;
      pol_pos  <= 1'b0;
      pol_neg  <= 1'b0;
    end else begin
      if (wr_half) buf_half <= wr_data;
      if (wr_top)  buf_top  <= wr_data;
      if (wr_dead) dead_q   <= wr_data;
      if (wr_pol) begin
        pol_pos <= wr_data[0];
        pol_neg <= wr_data[1];
      end
    end
  end

  for (genvar i = 0; i < NPH; i++) begin : g_duty
    logic hit;
    assign hit = wr_en && (wr_sel == SEL_W'(int'(SEL_DUTY0) + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   buf_duty[i] <= '0;
      else if (hit) buf_duty[i] <= wr_data;
    end
  end
endmodule

// File: rtl/cpwm_tri.sv
module cpwm_tri
  import cpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  input  logic [CW-1:0] start,
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  output logic [CW-1:0] cnt
);
  dir_e dir;

  function automatic logic [CW:0] tri_step(input logic [CW-1:0] c, input dir_e d,
                                           input logic [CW-1:0] l, input logic [CW-1:0] h);
    logic [CW:0] r;
    if (h == l)              r = {d, c};
    else if (d == DIR_UP)    r = (c >= h) ? {DIR_DOWN, c - 1'b1} : {DIR_UP, c + 1'b1};
    else                     r = (c <= l) ? {DIR_UP, c + 1'b1}   : {DIR_DOWN, c - 1'b1};
    return r;
  endfunction

  logic [CW:0] nxt;
  assign nxt = tri_step(cnt, dir, lo, hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      dir <= DIR_UP;
    end else if (load) begin
      cnt <= start;
      dir <= DIR_UP;
    end else if (run) begin
      cnt <= nxt[CW-1:0];
      dir <= dir_e'(nxt[CW]);
    end
  end
endmodule

// File: rtl/cpwm_leg.sv
module cpwm_leg #(
  parameter int CW = 16
) (
  input  logic          run,
  input  logic [CW-1:0] duty,
  input  logic [CW-1:0] half,
  input  logic [CW-1:0] lag_cnt,
  input  logic [CW-1:0] lead_cnt,
  input  logic          pol_pos,
  input  logic          pol_neg,
  output logic          pos_act,
  output logic          neg_act,
  output logic          out_pos,
  output logic          out_neg
);
  function automatic logic [CW-1:0] clamp_duty(input logic [CW-1:0] d, input logic [CW-1:0] h);
    return (d > h) ? h : d;
  endfunction

  logic [CW-1:0] dc;
  assign dc      = clamp_duty(duty, half);
  assign pos_act = run && (dc < lag_cnt);
  assign neg_act = run && (dc > lead_cnt);
  assign out_pos = pos_act ^ pol_pos;
  assign out_neg = neg_act ^ pol_neg;
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband
  import cpwm_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NPH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [CW-1:0]    wr_data,
  input  logic             mode_en,
  output logic [NPH-1:0]   pwm_pos,
  output logic [NPH-1:0]   pwm_neg
);
  logic                   mode_q, enter;
  logic [CW-1:0]          buf_half, buf_top, dead_q;
  logic [NPH-1:0][CW-1:0] buf_duty, cmp_duty;
  logic [CW-1:0]          cmp_half, cmp_top;
  logic                   pol_pos, pol_neg;
  logic [CW-1:0]          lag_cnt, lead_cnt;
  logic [NPH-1:0]         pos_act, neg_act;

  assign enter = mode_en && !mode_q;

  cpwm_regs #(.CW(CW), .NPH(NPH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .locked(mode_q), .buf_half(buf_half), .buf_top(buf_top), .dead_q(dead_q),
    .buf_duty(buf_duty), .pol_pos(pol_pos), .pol_neg(pol_neg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      cmp_half <= '0;
      cmp_top  <= '0;
      cmp_duty <= '0;
    end else begin
      mode_q <= mode_en;
      if (enter) begin
        cmp_half <= buf_half;
        cmp_top  <= buf_top;
        cmp_duty <= buf_duty;
      end
    end
  end

  cpwm_tri #(.CW(CW)) u_lag (
    .clk(clk), .rst_n(rst_n), .load(enter), .run(mode_q),
    .start('0), .lo('0), .hi(cmp_half), .cnt(lag_cnt)
  );

  cpwm_tri #(.CW(CW)) u_lead (
    .clk(clk), .rst_n(rst_n), .load(enter), .run(mode_q),
    .start(dead_q), .lo(dead_q), .hi(cmp_top), .cnt(lead_cnt)
  );

  for (genvar i = 0; i < NPH; i++) begin : g_phase
    cpwm_leg #(.CW(CW)) u_leg (
      .run(mode_q), .duty(cmp_duty[i]), .half(cmp_half),
      .lag_cnt(lag_cnt), .lead_cnt(lead_cnt),
      .pol_pos(pol_pos), .pol_neg(pol_neg),
      .pos_act(pos_act[i]), .neg_act(neg_act[i]),
      .out_pos(pwm_pos[i]), .out_neg(pwm_neg[i])
    );
  end
endmodule

// File: rtl/cpwm_deadband_chk.sv
module cpwm_deadband_chk #(
  parameter int CW  = 16,
  parameter int NPH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mode_q,
  input logic [NPH-1:0] pos_act,
  input logic [NPH-1:0] neg_act,
  input logic [NPH-1:0] pwm_pos,
  input logic [NPH-1:0] pwm_neg,
  input logic           pol_pos,
  input logic           pol_neg,
  input logic [CW-1:0]  buf_half,
  input logic [CW-1:0]  cmp_half,
  input logic [CW-1:0]  cmp_top,
  input logic [CW-1:0]  dead_q,
  input logic [CW-1:0]  lag_cnt,
  input logic [CW-1:0]  lead_cnt
);
  // R7: the two sides of a phase are never on together
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_act & neg_act) == '0);

  // R2: idle outputs sit at the polarity level
  a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (pwm_pos == {NPH{pol_pos}}) && (pwm_neg == {NPH{pol_neg}}));

  // R3: compare registers take the buffer values present before entry
  a_r3_entry_copy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q) |-> cmp_half == $past(buf_half));

  // R9: dead time cannot move while running
  a_r9_dead_locked: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q && $past(mode_q) |-> $stable(dead_q));

  // R4: counters stay Td apart when the top limit is consistent
  a_r4_offset: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q && (cmp_top == cmp_half + dead_q) |-> lead_cnt == lag_cnt + dead_q);

  // R4: lower counter moves by at most one per clock
  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q && $past(mode_q) |->
      (lag_cnt == $past(lag_cnt) + 1'b1) || (lag_cnt == $past(lag_cnt) - 1'b1) ||
      (lag_cnt == $past(lag_cnt)));
endmodule

bind cpwm_deadband cpwm_deadband_chk #(.CW(CW), .NPH(NPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .pos_act(pos_act), .neg_act(neg_act),
  .pwm_pos(pwm_pos), .pwm_neg(pwm_neg), .pol_pos(pol_pos), .pol_neg(pol_neg),
  .buf_half(buf_half), .cmp_half(cmp_half), .cmp_top(cmp_top), .dead_q(dead_q),
  .lag_cnt(lag_cnt), .lead_cnt(lead_cnt)
);

// File: tb/sim_cpwm_deadband.sv
module sim_cpwm_deadband;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        mode_en = 1'b0;
  logic [2:0]  pwm_pos, pwm_neg;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  cpwm_deadband #(.CW(16), .NPH(3)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mode_en(mode_en), .pwm_pos(pwm_pos), .pwm_neg(pwm_neg)
  );

  // reference model state
  int b_half = 0, b_top = 0, b_dead = 0, b_duty[3] = '{0, 0, 0};
  int m_pol = 0, m_mode = 0, m_t = 0, m_half = 0, m_td = 0, m_duty[3] = '{0, 0, 0};
  int last_side[3] = '{0, 0, 0};
  int gap[3] = '{0, 0, 0};

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      b_half = 0; b_top = 0; b_dead = 0; m_pol = 0; m_mode = 0; m_t = 0;
      for (int i = 0; i < 3; i++) b_duty[i] = 0;
    end else begin
      int was_on;
      was_on = m_mode;
      if (mode_en && !was_on) begin
        m_t = 0; m_half = b_half; m_td = b_dead;
        for (int i = 0; i < 3; i++) m_duty[i] = b_duty[i];
      end else if (was_on) m_t++;
      m_mode = mode_en;
      if (wr_en) begin
        case (wr_sel)
          3'd0: b_half = wr_data;
          3'd1: b_top = wr_data;
          3'd2: if (!was_on) b_dead = wr_data;
          3'd3, 3'd4, 3'd5: b_duty[wr_sel - 3] = wr_data;
          3'd6: if (!was_on) m_pol = wr_data[1:0];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      int exp_p, exp_n, p, lag, lead, dc, ap, an;
      exp_p = 0; exp_n = 0;
      for (int i = 0; i < 3; i++) begin
        ap = 0; an = 0;
        if (m_mode) begin
          p = m_t % (2 * m_half);
          lag = (p <= m_half) ? p : 2 * m_half - p;
          lead = lag + m_td;
          dc = (m_duty[i] > m_half) ? m_half : m_duty[i];
          ap = (dc < lag) ? 1 : 0;
          an = (dc > lead) ? 1 : 0;
        end
        exp_p |= (ap ^ (m_pol & 1)) << i;
        exp_n |= (an ^ ((m_pol >> 1) & 1)) << i;
      end
      check(cur_tag, pwm_pos == 3'(exp_p), pwm_pos, exp_p);
      check(cur_tag, pwm_neg == 3'(exp_n), pwm_neg, exp_n);
      if (m_mode) begin
        for (int i = 0; i < 3; i++) begin
          ap = pwm_pos[i] ^ (m_pol & 1);
          an = pwm_neg[i] ^ ((m_pol >> 1) & 1);
          check("R7 overlap", !(ap && an), ap + an, 1);
          if (ap || an) begin
            if (last_side[i] != 0 && last_side[i] != (ap ? 1 : 2))
              check("R7 dead band", gap[i] >= m_td, gap[i], m_td);
            last_side[i] = ap ? 1 : 2;
            gap[i] = 0;
          end else gap[i]++;
        end
      end else
        for (int i = 0; i < 3; i++) begin last_side[i] = 0; gap[i] = 0; end
    end
  end

  task automatic wr(input logic [2:0] s, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset pos", pwm_pos == 3'b000, pwm_pos, 0);
    check("R1 reset neg", pwm_neg == 3'b000, pwm_neg, 0);

    // R10: program buffers via select codes; R6: phase 2 duty above half
    cur_tag = "R10 setup";
    wr(3'd0, 20); wr(3'd1, 23); wr(3'd2, 3);
    wr(3'd3, 5); wr(3'd4, 12); wr(3'd5, 30);
    cur_tag = "R3/R4/R5/R6 run1";
    @(negedge clk); mode_en = 1'b1;
    idle(100);

    // R3: buffer writes while running; R9: dead time and polarity ignored
    cur_tag = "R3 buffers held";
    wr(3'd0, 12); wr(3'd3, 15);
    cur_tag = "R9 locked writes";
    wr(3'd2, 7); wr(3'd6, 3);
    idle(60);
    @(negedge clk); mode_en = 1'b0;
    @(negedge clk);
    check("R9 polarity kept", pwm_pos == 3'b000 && pwm_neg == 3'b000, {pwm_neg, pwm_pos}, 0);

    // R8/R2: inverted polarity while idle, then run with new buffers
    wr(3'd6, 3);
    @(negedge clk);
    check("R2 R8 idle high", pwm_pos == 3'b111 && pwm_neg == 3'b111, {pwm_neg, pwm_pos}, 63);
    cur_tag = "R2 idle";
    wr(3'd2, 2); wr(3'd1, 14); wr(3'd4, 0); wr(3'd5, 12);
    cur_tag = "R8 R5 run2";
    @(negedge clk); mode_en = 1'b1;
    idle(80);

    // zero dead time, normal polarity
    @(negedge clk); mode_en = 1'b0;
    cur_tag = "R2 idle2";
    wr(3'd2, 0); wr(3'd1, 12); wr(3'd6, 0);
    wr(3'd3, 4); wr(3'd4, 9); wr(3'd5, 40);
    cur_tag = "R4 R6 R7 run3";
    @(negedge clk); mode_en = 1'b1;
    idle(60);
    @(negedge clk); mode_en = 1'b0;
    idle(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule